// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing for a 50 Hz, non-interlaced, 312-line raster such as a small home computer drives into a television's RGB input. It advances once per character period, qualified by a character-rate enable that is nominally 1 MHz, so that one scan line lasts 64 character periods (64 µs). From a character column counter and a scan line counter it decodes active-low horizontal and vertical sync, a blanking flag, a display enable and a border enable.

One line timing serves two picture widths. The line holds a 40-character (320-pixel) window. A narrow-column mode shows data in only the first 32 characters of that window and paints the remaining 8 as border. In the same way, a short-rows mode shows data in only the middle 192 lines of the 240-line vertical window. Downstream pixel shifting and memory fetch use the column and line counts and the display enable.

For software that keeps time by counting frame pulses at 60 Hz, the block also produces a tick of about 60 Hz. It comes from a fractional accumulator on the character enable and has no relation to the real 50 Hz field.

Top module: `raster_timing`

## Requirements
- R1: `col` counts 0 to 63 and then wraps to 0. `line` advances by one when `col` wraps from 63 and runs 0 to 311 before wrapping to 0.
- R2: While `char_en` is low, `col`, `line` and `tick60` hold their values.
- R3: A synchronous `rst` sets `col` to 0, `line` to 0 and `tick60` to 0.
- R4: `hsync_n` is 0 exactly when `col` is between 48 and 51 inclusive, on every line.
- R5: `vsync_n` is 0 exactly when `line` is between 302 and 311 inclusive.
- R6: `blank` is 1 when `col` is between 46 and 57 inclusive, and also on every column of lines 0 to 9 and lines 302 to 311. It is 0 everywhere else.
- R7: With `narrow_cols`=0 and `short_rows`=0, `disp_en` is 1 exactly for `col` 0 to 39 on `line` 36 to 275.
- R8: With `narrow_cols`=1, `disp_en` is 1 only for `col` 0 to 31. Columns 32 to 39 of window lines give `border_en`=1.
- R9: With `short_rows`=1, `disp_en` is 1 only on `line` 60 to 251. The other lines of the 36 to 275 window give `border_en`=1 on window columns.
- R10: `border_en` is 1 exactly when both `blank` and `disp_en` are 0.
- R11: Counting enabled edges k from reset, `tick60` is 1 after edge k exactly when 60·k passes a multiple of 1,000,000. The first tick comes at k=16667 and the second at k=33334. Each tick lasts one character period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| char_en | input | 1 | Character-rate enable (one pulse per character period) |
| narrow_cols | input | 1 | 1 selects the 32-column data window |
| short_rows | input | 1 | 1 selects the 192-line data window |
| col | output | 6 | Character column within the line |
| line | output | 9 | Scan line within the field |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | Display data is shown |
| border_en | output | 1 | Border colour is shown |
| blank | output | 1 | Video blanked (porches, sync, vertical blanking) |
| tick60 | output | 1 | Legacy 60 Hz tick, one character period wide |

## Verification
The counters and `tick60` are registers that update on an enabled clock edge. The syncs, `blank`, `disp_en` and `border_en` are decoded combinationally from the counters. Every result is therefore valid one clock after the enabled edge that caused it, with no further pipeline delay. The bench drives inputs on the falling edge and compares on the next falling edge. After each rising edge it predicts the counter position and the accumulator crossing from its own count of enabled edges. For the hold test it leaves `char_en` low for many clocks and then confirms that one more enabled edge moves `col` by exactly one.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int H_ACTIVE = 40,
  parameter int H_NARROW = 32,
  parameter int H_RBORD  = 6,
  parameter int H_FP     = 2,
  parameter int H_SYNC   = 4,
  parameter int H_BP     = 6,
  parameter int H_LBORD  = 6,
  parameter int V_BLANK  = 10,
  parameter int V_TOP    = 26,
  parameter int V_ACT    = 240,
  parameter int V_SHORT  = 192,
  parameter int V_BOT    = 26,
  parameter int V_RET    = 10,
  parameter int CHAR_HZ  = 1000000,
  parameter int TICK_HZ  = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       char_en,
  input  logic       narrow_cols,
  input  logic       short_rows,
  output logic [$clog2(H_ACTIVE+H_RBORD+H_FP+H_SYNC+H_BP+H_LBORD)-1:0] col,
  output logic [$clog2(V_BLANK+V_TOP+V_ACT+V_BOT+V_RET)-1:0] line,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       disp_en,
  output logic       border_en,
  output logic       blank,
  output logic       tick60
);
  localparam int H_TOTAL = H_ACTIVE + H_RBORD + H_FP + H_SYNC + H_BP + H_LBORD;
  localparam int V_TOTAL = V_BLANK + V_TOP + V_ACT + V_BOT + V_RET;
  localparam int CW = $clog2(H_TOTAL);
  localparam int LW = $clog2(V_TOTAL);
  localparam int AW = $clog2(CHAR_HZ + TICK_HZ) + 1;

  localparam logic [CW-1:0] C_LAST  = CW'(H_TOTAL - 1);
  localparam logic [CW-1:0] C_WIDE  = CW'(H_ACTIVE);
  localparam logic [CW-1:0] C_NAR   = CW'(H_NARROW);
  localparam logic [CW-1:0] C_HB0   = CW'(H_ACTIVE + H_RBORD);
  localparam logic [CW-1:0] C_HS0   = CW'(H_ACTIVE + H_RBORD + H_FP);
  localparam logic [CW-1:0] C_HS1   = CW'(H_ACTIVE + H_RBORD + H_FP + H_SYNC);
  localparam logic [CW-1:0] C_HB1   = CW'(H_ACTIVE + H_RBORD + H_FP + H_SYNC + H_BP);

  localparam int V_OFS = (V_ACT - V_SHORT) / 2;
  localparam logic [LW-1:0] L_LAST  = LW'(V_TOTAL - 1);
  localparam logic [LW-1:0] L_VB1   = LW'(V_BLANK);
  localparam logic [LW-1:0] L_W0    = LW'(V_BLANK + V_TOP);
  localparam logic [LW-1:0] L_W1    = LW'(V_BLANK + V_TOP + V_ACT);
  localparam logic [LW-1:0] L_S0    = LW'(V_BLANK + V_TOP + V_OFS);
  localparam logic [LW-1:0] L_S1    = LW'(V_BLANK + V_TOP + V_OFS + V_SHORT);
  localparam logic [LW-1:0] L_VR0   = LW'(V_BLANK + V_TOP + V_ACT + V_BOT);

  localparam logic [AW-1:0] A_STEP  = AW'(TICK_HZ);
  localparam logic [AW-1:0] A_MOD   = AW'(CHAR_HZ);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_sum;
  logic          acc_wrap;
  logic          h_act, v_act, h_blank, v_blank;

  assign acc_sum  = acc_q + A_STEP;
  assign acc_wrap = acc_sum >= A_MOD;

  always_ff @(posedge clk) begin
    if (rst) begin
      col    <= '0;
      line   <= '0;
      acc_q  <= '0;
      tick60 <= 1'b0;
    end else if (char_en) begin
      col    <= (col == C_LAST) ? '0 : col + 1'b1;
      if (col == C_LAST)
        line <= (line == L_LAST) ? '0 : line + 1'b1;
      acc_q  <= acc_wrap ? acc_sum - A_MOD : acc_sum;
      tick60 <= acc_wrap;
    end
  end

  assign h_act   = col < (narrow_cols ? C_NAR : C_WIDE);
  assign v_act   = short_rows ? (line >= L_S0 && line < L_S1)
                              : (line >= L_W0 && line < L_W1);
  assign h_blank = col >= C_HB0 && col < C_HB1;
  assign v_blank = line < L_VB1 || line >= L_VR0;

  assign hsync_n   = !(col >= C_HS0 && col < C_HS1);
  assign vsync_n   = !(line >= L_VR0);
  assign blank     = h_blank || v_blank;
  assign disp_en   = h_act && v_act && !blank;
  assign border_en = !blank && !disp_en;
endmodule

module raster_timing_chk #(
  parameter int CW = 6,
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          char_en,
  input logic [CW-1:0] col,
  input logic [LW-1:0] line,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          disp_en,
  input logic          border_en,
  input logic          blank,
  input logic          tick60
);
  p_col_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (char_en && col == CW'(63)) |=> (col == '0));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !char_en |=> ($stable(col) && $stable(line) && $stable(tick60)));
  p_reset_r3: assert property (@(posedge clk)
    rst |=> (col == '0 && line == '0 && !tick60));
  p_hsync_start_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> (col == CW'(48)));
  p_vsync_blank_r5: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> blank);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    $countones({disp_en, border_en, blank}) == 1);
  p_tick_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (tick60 && char_en) |=> !tick60);
endmodule

bind raster_timing raster_timing_chk #(.CW(CW), .LW(LW)) u_chk (.*);

// File: tb/raster_timing_test.sv
`timescale 1ns/1ps
module raster_timing_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_en = 1'b0;
  logic narrow_cols = 1'b0;
  logic short_rows = 1'b0;
  logic [5:0] col;
  logic [8:0] line;
  logic hsync_n, vsync_n, disp_en, border_en, blank, tick60;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  raster_timing uut (
    .clk(clk), .rst(rst), .char_en(char_en),
    .narrow_cols(narrow_cols), .short_rows(short_rows),
    .col(col), .line(line), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_en(disp_en), .border_en(border_en), .blank(blank), .tick60(tick60)
  );

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    char_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit e_blank(int c, int l);
    return (c >= 46 && c <= 57) || l <= 9 || l >= 302;
  endfunction

  function automatic bit e_disp(int c, int l, bit nar, bit sh);
    bit h, v;
    h = c < (nar ? 32 : 40);
    v = sh ? (l >= 60 && l <= 251) : (l >= 36 && l <= 275);
    return h && v && !e_blank(c, l);
  endfunction

  task automatic t_reset();
    do_reset();
    check(col == 0 && line == 0 && !tick60, "R3",
          $sformatf("col=%0d line=%0d tick=%0b", col, line, tick60), "col=0 line=0 tick=0");
  endtask

  task automatic t_field(input bit nar, input bit sh);
    int bad1 = 0, bad4 = 0, bad5 = 0, bad6 = 0, bad7 = 0, bad10 = 0;
    string m1 = "", m4 = "", m5 = "", m6 = "", m7 = "", m10 = "";
    string rq;
    narrow_cols = nar;
    short_rows = sh;
    do_reset();
    char_en = 1'b1;
    for (int n = 0; n < 312 * 64 + 1; n++) begin
      int c = n % 64;
      int l = (n / 64) % 312;
      bit eb = e_blank(c, l);
      bit ed = e_disp(c, l, nar, sh);
      if (col != c || line != l) begin
        if (bad1 == 0) m1 = $sformatf("n=%0d col=%0d line=%0d vs %0d/%0d", n, col, line, c, l);
        bad1++;
      end
      if (hsync_n != !(c >= 48 && c <= 51)) begin
        if (bad4 == 0) m4 = $sformatf("col=%0d hsync_n=%0b", c, hsync_n);
        bad4++;
      end
      if (vsync_n != !(l >= 302)) begin
        if (bad5 == 0) m5 = $sformatf("line=%0d vsync_n=%0b", l, vsync_n);
        bad5++;
      end
      if (blank != eb) begin
        if (bad6 == 0) m6 = $sformatf("col=%0d line=%0d blank=%0b exp %0b", c, l, blank, eb);
        bad6++;
      end
      if (disp_en != ed) begin
        if (bad7 == 0) m7 = $sformatf("col=%0d line=%0d disp=%0b exp %0b", c, l, disp_en, ed);
        bad7++;
      end
      if (border_en != (!eb && !ed)) begin
        if (bad10 == 0) m10 = $sformatf("col=%0d line=%0d border=%0b exp %0b", c, l, border_en, !eb && !ed);
        bad10++;
      end
      @(negedge clk);
    end
    char_en = 1'b0;
    rq = !nar && !sh ? "R7" : (nar ? "R8" : "R9");
    check(bad1 == 0, "R1", $sformatf("%0d mismatches, %s", bad1, m1), "0 mismatches");
    check(bad4 == 0, "R4", $sformatf("%0d mismatches, %s", bad4, m4), "0 mismatches");
    check(bad5 == 0, "R5", $sformatf("%0d mismatches, %s", bad5, m5), "0 mismatches");
    check(bad6 == 0, "R6", $sformatf("%0d mismatches, %s", bad6, m6), "0 mismatches");
    check(bad7 == 0, rq,   $sformatf("%0d mismatches, %s", bad7, m7), "0 mismatches");
    if (nar && sh) check(bad7 == 0, "R9", $sformatf("%0d mismatches", bad7), "0 mismatches");
    check(bad10 == 0, "R10", $sformatf("%0d mismatches, %s", bad10, m10), "0 mismatches");
  endtask

  task automatic t_hold();
    narrow_cols = 1'b0;
    short_rows = 1'b0;
    do_reset();
    char_en = 1'b1;
    repeat (70) @(negedge clk);
    check(col == 6 && line == 1, "R1",
          $sformatf("col=%0d line=%0d", col, line), "col=6 line=1");
    char_en = 1'b0;
    repeat (25) @(negedge clk);
    check(col == 6 && line == 1 && !tick60, "R2",
          $sformatf("col=%0d line=%0d tick=%0b", col, line, tick60), "col=6 line=1 tick=0");
    char_en = 1'b1;
    @(negedge clk);
    char_en = 1'b0;
    check(col == 7 && line == 1, "R2",
          $sformatf("col=%0d line=%0d", col, line), "col=7 line=1");
  endtask

  task automatic t_tick();
    int bad = 0, cnt = 0, first = 0;
    string m = "";
    do_reset();
    char_en = 1'b1;
    for (int k = 1; k <= 33336; k++) begin
      longint a, b;
      bit e;
      @(negedge clk);
      a = (64'(k) * 60) / 1000000;
      b = (64'(k - 1) * 60) / 1000000;
      e = (a != b);
      if (tick60 != e) begin
        if (bad == 0) m = $sformatf("k=%0d tick=%0b exp %0b", k, tick60, e);
        bad++;
      end
      if (tick60) begin
        cnt++;
        if (first == 0) first = k;
      end
    end
    char_en = 1'b0;
    check(bad == 0, "R11", $sformatf("%0d mismatches, %s", bad, m), "0 mismatches");
    check(first == 16667, "R11", $sformatf("first=%0d", first), "first=16667");
    check(cnt == 2, "R11", $sformatf("ticks=%0d", cnt), "ticks=2");
  endtask

  initial begin
    t_reset();
    t_hold();
    t_field(1'b0, 1'b0);
    t_field(1'b1, 1'b1);
    t_tick();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule